// File: doc/BRIEF.md
# Four-Channel Sampling Sequencer with Implicit Readout

This block is the digital control core of a four-channel converter that samples all channels at once. A rising edge on the asynchronous start input is synchronised into the conversion clock domain. On the cycle that edge is recognised, all four sample/hold flags go high together and the core starts a 12-bit successive-approximation search on channel 1. It drives a trial code to an external DAC and reads back a one-bit comparator decision. Channels 2, 3 and 4 follow in strict order. Each finished code goes into its own result register. When the fourth result is stored, the hold flags drop and an active-low completion interrupt is raised.

A host reads the results through a single chip-select/read port. An internal pointer selects the register to return. A convert start sets the pointer back to channel 1, and the end of each read moves it on by one. The registers cannot be addressed individually. The first read after a conversion releases the interrupt. The data bus is enabled only while chip select and read are both low.

Top module: `quad_sar_sequencer`

## Requirements
- R1: After reset, intN is 1, holdFlags is 0000, dacCode is 0, dataOe is 0 and dataOut is 0.
- R2: The start input passes through a two-stage synchroniser. All four holdFlags go from 0 to 1 together on the third rising clock edge after convStart goes high. They stay at 1111 for the whole conversion and return to 0000 on the same edge that intN falls.
- R3: Each channel search is MSB first and takes 12 cycles. The first trial code of every channel is 0x800. Each trial is the bits accepted so far plus the bit under test. That bit is kept when cmpAbove is 1 (cmpAbove = 1 means the DAC level is at or below the held input).
- R4: A stored result is the offset-binary search code with its MSB inverted, which gives two's complement. A search code of 0xFFF gives 0x7FF, 0x000 gives 0x800 and 0x800 gives 0x000.
- R5: Channels are converted in the order 1, 2, 3, 4, each into its own register. intN falls on the 51st rising edge after convStart goes high: 3 sync/start edges plus 48 bit steps.
- R6: Successive reads after a conversion return channel 1, 2, 3 and 4 in that order. A fifth read returns channel 1 again.
- R7: intN returns to 1 on the first clock edge at which a read (csN and rdN both low) is seen after completion. It stays low until then.
- R8: dataOe is 1 exactly while csN and rdN are both low. dataOut shows the selected register then and is 0 otherwise.
- R9: A convStart rising edge during a conversion is ignored. Completion timing and all four results are unchanged.
- R10: A read during a conversion returns the register the pointer selects and does not advance the pointer.
- R11: A new conversion sets the pointer back to channel 1, even after a partial readout.
- R12: With csN high, a low rdN neither enables the bus nor advances the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | Asynchronous start; rising edge begins a conversion |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| cmpAbove | input | 1 | Comparator: 1 when the DAC level is at or below the held input |
| dacCode | output | 12 | Trial code to the DAC (0 when idle) |
| holdFlags | output | 4 | Per-channel hold command, 1 = hold |
| intN | output | 1 | Active-low conversion-complete interrupt |
| dataOut | output | 12 | Read data, valid while dataOe is 1 |
| dataOe | output | 1 | Output enable for the external tri-state driver |

## Verification
A bit counter that is off by one shows at once as a changed interrupt edge (the 51-edge count) and as a wrong code on every channel. A channel counter that skips or repeats puts a result in the wrong register, and the ordered readout shows this on the first read. A pointer that fails to reset or advances at the wrong time returns a value from a neighbouring channel at the next read. A lost hold or a restart accepted mid-conversion shows as results that follow the live inputs instead of the values captured at the start.

// File: rtl/qss_pkg.sv
package qss_pkg;
  localparam int RES_BITS    = 12;
  localparam int NUM_CH      = 4;
  localparam int SYNC_STAGES = 2;
  localparam int BIT_W       = $clog2(RES_BITS);
  localparam int CH_W        = $clog2(NUM_CH);

  typedef struct packed {
    logic            trial;   // a search step is active this cycle
    logic            store;   // last bit of the current channel
    logic            clear;   // start of a new conversion
    logic            oe;      // bus read active
    logic [BIT_W-1:0] bitIdx;
    logic [CH_W-1:0]  chan;
    logic [CH_W-1:0]  rdPtr;
  } ctrlStrobes_t;
endpackage

// File: rtl/qss_control.sv
module qss_control
  import qss_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         convStart,
  input  logic         csN,
  input  logic         rdN,
  output ctrlStrobes_t strb,
  output logic [NUM_CH-1:0] holdFlags,
  output logic         intN
);
  localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(RES_BITS - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

  logic [SYNC_STAGES:0] syncChain;
  logic startRise, startGo;
  logic busy, holding, prevAct, readAct;
  logic [BIT_W-1:0] bitIdx;
  logic [CH_W-1:0]  chan, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], convStart};
  end

  assign startRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];
  assign startGo   = startRise & ~busy;
  assign readAct   = ~csN & ~rdN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      holding <= 1'b0;
      bitIdx  <= TOP_BIT;
      chan    <= '0;
      rdPtr   <= '0;
      intN    <= 1'b1;
      prevAct <= 1'b0;
    end else begin
      prevAct <= readAct;
      if (readAct && !prevAct) intN <= 1'b1;
      if (startGo) begin
        busy    <= 1'b1;
        holding <= 1'b1;
        bitIdx  <= TOP_BIT;
        chan    <= '0;
        rdPtr   <= '0;
      end else if (busy) begin
        if (bitIdx == '0) begin
          bitIdx <= TOP_BIT;
          if (chan == LAST_CH) begin
            busy    <= 1'b0;
            holding <= 1'b0;
            intN    <= 1'b0;
          end else begin
            chan <= chan + 1'b1;
          end
        end else begin
          bitIdx <= bitIdx - 1'b1;
        end
      end else if (prevAct && !readAct) begin
        rdPtr <= (rdPtr == LAST_CH) ? '0 : rdPtr + 1'b1;
      end
    end
  end

  assign holdFlags   = {NUM_CH{holding}};
  assign strb.trial  = busy;
  assign strb.store  = busy && (bitIdx == '0);
  assign strb.clear  = startGo;
  assign strb.oe     = readAct;
  assign strb.bitIdx = bitIdx;
  assign strb.chan   = chan;
  assign strb.rdPtr  = rdPtr;
endmodule

// File: rtl/qss_datapath.sv
module qss_datapath
  import qss_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic                cmpAbove,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] dataOut
);
  localparam int MSB = RES_BITS - 1;

  logic [RES_BITS-1:0] acc, mask, trialCode, nextAcc;
  logic [RES_BITS-1:0] resReg [NUM_CH];

  assign mask      = {{(RES_BITS-1){1'b0}}, 1'b1} << strb.bitIdx;
  assign trialCode = acc | mask;
  assign nextAcc   = cmpAbove ? trialCode : acc;
  assign dacCode   = strb.trial ? trialCode : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        acc <= '0;
    else if (strb.clear || strb.store) acc <= '0;
    else if (strb.trial)              acc <= nextAcc;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [RES_BITS-1:0] chReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        chReg <= '0;
      else if (strb.store && strb.chan == CH_W'(c))
        chReg <= {~nextAcc[MSB], nextAcc[MSB-1:0]};
    end
    assign resReg[c] = chReg;
  end

  assign dataOut = strb.oe ? resReg[strb.rdPtr] : '0;
endmodule

// File: rtl/quad_sar_sequencer.sv
module quad_sar_sequencer
  import qss_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                convStart,
  input  logic                csN,
  input  logic                rdN,
  input  logic                cmpAbove,
  output logic [RES_BITS-1:0] dacCode,
  output logic [NUM_CH-1:0]   holdFlags,
  output logic                intN,
  output logic [RES_BITS-1:0] dataOut,
  output logic                dataOe
);
  ctrlStrobes_t strb;

  qss_control i_control (
    .clk(clk), .rstN(rstN), .convStart(convStart), .csN(csN), .rdN(rdN),
    .strb(strb), .holdFlags(holdFlags), .intN(intN)
  );

  qss_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpAbove(cmpAbove),
    .dacCode(dacCode), .dataOut(dataOut)
  );

  assign dataOe = strb.oe;
endmodule

// File: rtl/qss_checker.sv
module qss_checker
  import qss_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                rdN,
  input logic                intN,
  input logic [NUM_CH-1:0]   holdFlags,
  input logic [RES_BITS-1:0] dacCode,
  input logic                dataOe,
  input logic [RES_BITS-1:0] dataOut
);
  AST_HOLD_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlags == '0) || (holdFlags == '1)); // R2
  AST_HOLD_DROP_AT_INT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> (holdFlags == '0) && ($past(holdFlags) == '1)); // R2
  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rstN)
    ((holdFlags == '1) && ($past(holdFlags) == '0)) |-> dacCode == {1'b1, {(RES_BITS-1){1'b0}}}); // R3
  AST_IDLE_DAC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlags == '0) |-> dacCode == '0); // R3
  AST_INT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !csN && !rdN) |=> intN); // R7
  AST_INT_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && (csN || rdN)) |=> !intN); // R7
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0); // R8
endmodule

bind quad_sar_sequencer qss_checker i_qss_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .intN(intN),
  .holdFlags(holdFlags), .dacCode(dacCode), .dataOe(dataOe), .dataOut(dataOut)
);

// File: tb/test_quad_sar_sequencer.sv
`timescale 1ns/1ps
module test_quad_sar_sequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convStart = 1'b0, csN = 1'b1, rdN = 1'b1;
  logic cmpAbove;
  logic [11:0] dacCode, dataOut;
  logic [3:0]  holdFlags;
  logic intN, dataOe;

  int nTests = 0, nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  quad_sar_sequencer i_quad_sar_sequencer (
    .clk(clk), .rstN(rstN), .convStart(convStart), .csN(csN), .rdN(rdN),
    .cmpAbove(cmpAbove), .dacCode(dacCode), .holdFlags(holdFlags),
    .intN(intN), .dataOut(dataOut), .dataOe(dataOe)
  );

  // Analog model: live inputs captured when hold is asserted
  logic [47:0] liveVal = '0, heldVal = '0;
  logic [1:0]  firstCnt = '0;
  logic [1:0]  curChan;
  logic [11:0] heldSel;

  always @(posedge holdFlags[0]) heldVal = liveVal;
  always @(posedge clk) if (dacCode == 12'h800) firstCnt <= firstCnt + 2'd1;
  assign curChan  = (dacCode == 12'h800) ? firstCnt : firstCnt - 2'd1;
  assign heldSel  = heldVal[curChan*12 +: 12];
  assign cmpAbove = (dacCode <= heldSel);

  function automatic logic [11:0] expOf(input logic [47:0] v, input int ch);
    return v[ch*12 +: 12] ^ 12'h800;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0: plain, 1: restart pulse mid-run, 2: read mid-run
  task automatic convOnce(input logic [47:0] v, input int mode, input logic [11:0] midExp);
    liveVal = v;
    @(negedge clk) convStart = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) chk("R2 hold not yet", holdFlags, 4'h0);
    @(posedge clk);
    @(negedge clk) begin
      chk("R2 hold on 3rd edge", holdFlags, 4'hF);
      convStart = 1'b0;
      liveVal = ~v;             // inputs change after hold
    end
    repeat (20) @(posedge clk);
    @(negedge clk) begin
      if (mode == 1) convStart = 1'b1;
      if (mode == 2) begin csN = 1'b0; rdN = 1'b0; end
      #1;
      if (mode == 2) chk("R10 read mid conversion", dataOut, midExp);
    end
    @(posedge clk);
    @(negedge clk) begin
      chk("R2 hold through conversion", holdFlags, 4'hF);
      convStart = 1'b0; csN = 1'b1; rdN = 1'b1;
    end
    repeat (26) @(posedge clk);
    @(negedge clk) chk("R5 intN before 51st edge", intN, 1'b1);
    @(posedge clk);
    @(negedge clk) begin
      chk("R5 intN on 51st edge", intN, 1'b0);
      chk("R2 hold released", holdFlags, 4'h0);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) chk("R7 intN stays low", intN, 1'b0);
  endtask

  task automatic readOne(input string tag, input logic [11:0] exp);
    @(negedge clk) begin csN = 1'b0; rdN = 1'b0; end
    #1;
    chk("R8 oe during read", dataOe, 1'b1);
    chk(tag, dataOut, exp);
    @(negedge clk) begin csN = 1'b1; rdN = 1'b1; end
    #1;
    chk("R8 bus quiet", {dataOe, dataOut}, 13'h0);
  endtask

  task automatic readAll(input logic [47:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      readOne((k < 4) ? "R6 R4 ordered readout" : "R6 wrap to ch1", expOf(v, k % 4));
      if (k == 0) chk("R7 intN released", intN, 1'b1);
    end
  endtask

  localparam logic [47:0] VEC [4] = '{
    {12'h7FF, 12'h800, 12'h000, 12'hFFF},
    {12'hAAA, 12'h555, 12'hABC, 12'h123},
    {12'h801, 12'h7FE, 12'hFFE, 12'h001},
    {12'h400, 12'hC00, 12'h3FF, 12'hC01}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) begin
      chk("R1 intN", intN, 1'b1);
      chk("R1 hold", holdFlags, 4'h0);
      chk("R1 dac", dacCode, 12'h0);
      chk("R1 bus", {dataOe, dataOut}, 13'h0);
      rstN = 1'b1;
    end
    repeat (2) @(posedge clk);

    for (int i = 0; i < 4; i++) begin
      convOnce(VEC[i], 0, 12'h0);
      readAll(VEC[i], 5);
    end

    // R9: restart during conversion ignored
    convOnce(VEC[1], 1, 12'h0);
    readAll(VEC[1], 4);

    // R10: read mid conversion shows ch1 already stored, pointer stays
    convOnce(VEC[2], 2, expOf(VEC[2], 0));
    readAll(VEC[2], 4);

    // R11: partial readout then new conversion
    convOnce(VEC[0], 0, 12'h0);
    readOne("R11 partial read 1", expOf(VEC[0], 0));
    readOne("R11 partial read 2", expOf(VEC[0], 1));
    convOnce(VEC[3], 0, 12'h0);
    readOne("R11 pointer back to ch1", expOf(VEC[3], 0));

    // R12: read strobe without chip select
    @(negedge clk) begin csN = 1'b1; rdN = 1'b0; end
    #1 chk("R12 no oe without cs", {dataOe, dataOut}, 13'h0);
    @(negedge clk) rdN = 1'b1;
    readOne("R12 pointer not advanced", expOf(VEC[3], 1));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule